// File: doc/BRIEF.md
# Aging Burst Arbiter

This block picks which of several requesters may move one 32-byte burst to memory next. Each requester raises a request line and supplies a static priority code. A request that has been seen is held pending inside the block until it is granted. Normally the pending request with the best priority wins. A second rule stops low-priority requesters from being starved. The block remembers the order in which pending requests arrived. It also counts how many bursts have completed since the earliest-arrived request last got service. Once that count reaches a programmable limit, the earliest-arrived request is served next, whatever its priority.

Only one grant is outstanding at any time. A grant stays asserted until the memory side reports that the burst has completed. The next decision is made one cycle after that report. A small limit shortens the worst-case wait of old requests, at some cost in throughput for urgent traffic. A limit of zero turns the block into a plain first-come first-served scheduler.

Top module: `burst_age_arbiter`

## Requirements
- R1: The grant vector has at most one bit set in every cycle.
- R2: A grant stays unchanged until burst_done is sampled high. The grant is then zero for exactly one cycle, after which the next grant may appear.
- R3: A requester whose req bit is sampled high, and which does not hold the grant or receive it at that edge, becomes pending. It stays pending, even if req drops, until it is granted. Only pending requesters are granted.
- R4: While the burst counter is below age_limit, the grant goes to the pending requester with the numerically lowest 3-bit priority code (0 is most urgent). Ties go to the lowest requester index.
- R5: Arrival order is tracked per pending request. The oldest request is the earliest to become pending. Among requests that become pending at the same edge, the lower index counts as older.
- R6: The burst counter increments (saturating) on each completed burst that was not granted to the oldest request. It clears when the oldest request is granted and when nothing is pending. When it is at or above age_limit, the next grant goes to the oldest request.
- R7: With age_limit equal to 0, requests are granted strictly in arrival order.
- R8: After reset no grant is asserted and nothing is pending.
- R9: burst_done sampled while no grant is outstanding has no effect on the grant or on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N (4) | Request line, one bit per requester |
| prio | input | N*PW (12) | Priority code per requester; requester i uses bits [i*PW +: PW] |
| age_limit | input | LW (8) | Number of completed bursts before the oldest request is forced |
| burst_done | input | 1 | Completion of the burst currently granted |
| grant | output | N (4) | One-hot grant, zero when no burst is outstanding |

## Verification
Two functions can land on the same edge. The first is the entry of a new request into the age order. The second is the arbitration decision, which can pick a different requester or promote the oldest one. Random traffic drives simultaneous arrivals on several lines while the arbiter goes idle after a completion. The same edge then both grants and appends, and a requester that still holds req at the end of its own burst re-enters as the newest arrival. Each cycle the grant is compared with a bench model that keeps an ordered list of pending indices and a completion counter. A directed starvation case and sweeps of the age limit, including zero and the value 3, show when the promotion fires.

// File: rtl/burst_age_arbiter.sv
module burst_age_arbiter #(
  parameter int N  = 4,
  parameter int PW = 3,
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  input  logic [LW-1:0]   age_limit,
  input  logic            burst_done,
  output logic [N-1:0]    grant
);

  localparam logic [LW-1:0] CNT_MAX = '1;

  logic [N-1:0]  pend;
  logic [N-1:0]  older [N];
  logic [LW-1:0] cnt;
  logic          cur_old;

  logic [N-1:0] oldest_oh, pri_oh, pick, enter, stay;
  logic         busy, fire, aged, pick_is_old;

  assign busy        = |grant;
  assign fire        = !busy && |pend;
  assign aged        = cnt >= age_limit;
  assign pick        = aged ? oldest_oh : pri_oh;
  assign pick_is_old = |(pick & oldest_oh);
  assign stay        = pend & ~(fire ? pick : '0);
  assign enter       = req & ~pend & ~grant & ~(fire ? pick : '0);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && pend[j] && older[j][i]) beaten = 1'b1;
      oldest_oh[i] = pend[i] && !beaten;
    end
  end

  always_comb begin
    logic          found;
    logic [PW-1:0] best;
    found  = 1'b0;
    best   = '0;
    pri_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!found || prio[i*PW +: PW] < best)) begin
        found  = 1'b1;
        best   = prio[i*PW +: PW];
        pri_oh = '0;
        pri_oh[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      grant   <= '0;
      cur_old <= 1'b0;
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else begin
      pend <= stay | enter;
      if (busy && burst_done) grant <= '0;
      else if (fire) begin
        grant   <= pick;
        cur_old <= pick_is_old;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j) begin
            if (enter[j]) older[i][j] <= stay[i] || (enter[i] && i < j);
            else if (enter[i]) older[i][j] <= 1'b0;
          end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (pend == '0) cnt <= '0;
    else if (fire && pick_is_old) cnt <= '0;
    else if (busy && burst_done && !cur_old && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_done) |=> $stable(grant));

  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && burst_done) |=> (grant == '0));

  p_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && |pend) |=> ((grant & $past(pend)) == grant) && (grant != '0));

  p_aged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && |pend && cnt >= age_limit) |=> (grant == $past(oldest_oh)));

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pend == '0) |=> (grant == '0 && cnt == '0));

endmodule

// File: tb/burst_age_arbiter_test.sv
module burst_age_arbiter_test;
  localparam int N = 4, PW = 3, LW = 8;
  localparam int CMAX = (1 << LW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N*PW-1:0] prio = '0;
  logic [LW-1:0] age_limit = '0;
  logic burst_done = 1'b0;
  logic [N-1:0] grant;

  always #2 clk = ~clk;

  burst_age_arbiter #(.N(N), .PW(PW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
    .age_limit(age_limit), .burst_done(burst_done), .grant(grant));

  int vectors = 0, miscompares = 0;
  int q[$];
  bit m_busy = 0, m_old = 0;
  int m_cur = 0, m_cnt = 0;
  string tag = "R8";

  function automatic logic [N-1:0] model_grant();
    return m_busy ? (N'(1) << m_cur) : '0;
  endfunction

  function automatic bit in_q(int idx);
    foreach (q[k]) if (q[k] == idx) return 1;
    return 0;
  endfunction

  function automatic int model_pick();
    int best = -1;
    if (m_cnt >= int'(age_limit)) return q[0];
    for (int i = 0; i < N; i++)
      if (in_q(i) && (best < 0 || prio[i*PW +: PW] < prio[best*PW +: PW])) best = i;
    return best;
  endfunction

  task automatic model_step();
    bit pre_empty = (q.size() == 0);
    bit pre_busy  = m_busy;
    bit done_hit  = 0;
    int g = -1;
    if (pre_busy) begin
      if (burst_done) begin m_busy = 0; done_hit = 1; end
    end else if (!pre_empty) begin
      g = model_pick();
      m_old = (g == q[0]);
      m_busy = 1; m_cur = g;
      foreach (q[k]) if (q[k] == g) begin q.delete(k); break; end
    end
    if (pre_empty) m_cnt = 0;
    else if (g >= 0 && m_old) m_cnt = 0;
    else if (done_hit && !m_old && m_cnt < CMAX) m_cnt++;
    for (int i = 0; i < N; i++)
      if (req[i] && !in_q(i) && !(pre_busy && m_cur == i) && g != i) q.push_back(i);
  endtask

  task automatic check_cycle();
    logic [N-1:0] exp = model_grant();
    vectors++;
    if (grant !== exp) begin
      miscompares++;
      $display("FAIL %s: grant=%b expected=%b at %0t", tag, grant, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_cycle();
  endtask

  task automatic run_random(int n, int lim, string t, int req_pct, bit done_any);
    tag = t;
    for (int c = 0; c < n; c++) begin
      age_limit = LW'(lim);
      for (int i = 0; i < N; i++) begin
        req[i] = ($urandom % 100) < req_pct;
        prio[i*PW +: PW] = PW'($urandom);
      end
      burst_done = (done_any || grant != '0) ? (($urandom % 3) == 0) : 1'b0;
      cycle();
    end
  endtask

  initial begin
    int others;
    bit got0;
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    tag = "R8";
    check_cycle();
    rst_n = 1'b1;
    @(negedge clk);
    check_cycle();

    // R4/R5/R6 mixed traffic, R1/R2/R3 checked every cycle
    run_random(3000, 5, "R4", 40, 0);
    run_random(3000, 3, "R6", 60, 0);
    run_random(3000, 0, "R7", 50, 0);
    run_random(3000, 255, "R4", 70, 0);
    run_random(2000, 1, "R5", 90, 0);
    run_random(2000, 2, "R9", 20, 1);

    // R6 directed starvation: low-urgency requester 0 against two urgent ones
    tag = "R6";
    req = '0; burst_done = 0; age_limit = 8'd3;
    repeat (20) begin cycle(); burst_done = (grant != '0); end
    prio = '0;
    prio[0 +: PW] = 3'd7;
    req = 4'b0111;
    burst_done = 0;
    others = 0; got0 = 0;
    for (int c = 0; c < 60 && !got0; c++) begin
      cycle();
      burst_done = (grant != '0);
      if (grant[0]) got0 = 1;
      else if (grant != '0 && burst_done) others++;
    end
    vectors++;
    if (!got0 || others != 3) begin
      miscompares++;
      $display("FAIL R6: bursts before promotion=%0d expected=3 (served=%0d)", others, got0);
    end

    // R7 directed: limit 0 serves in arrival order regardless of priority
    tag = "R7";
    req = '0; burst_done = 0; age_limit = '0;
    repeat (20) begin cycle(); burst_done = (grant != '0); end
    burst_done = 0;
    prio = {3'd0, 3'd1, 3'd2, 3'd7};
    req = 4'b0001; cycle(); req = 4'b0000;
    begin
      logic [N-1:0] seen [$];
      req = 4'b1000; cycle(); req = 4'b0100; cycle(); req = 4'b0000;
      for (int c = 0; c < 40 && seen.size() < 3; c++) begin
        burst_done = (grant != '0);
        if (grant != '0) seen.push_back(grant);
        cycle();
      end
      vectors++;
      if (seen.size() < 3 || seen[0] != 4'b0001 || seen[1] != 4'b1000 || seen[2] != 4'b0100) begin
        miscompares++;
        $display("FAIL R7: order=%p expected=0001,1000,0100", seen);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule